// File: doc/BRIEF.md
# CAN Receive Message Queue

This block holds complete received CAN messages between the receive engine and software. The engine offers one message per cycle on a valid strobe: a 32-bit identifier word, a 4-bit length code and two 32-bit data words. Each accepted message goes into a circular store whose depth is a build parameter. Messages leave in arrival order.

Software sees only the oldest stored message. It reads it as four 32-bit words at fixed byte offsets. Reads are side-effect free, with one exception: reading the second data word retires the head message. Software must therefore read that word for every frame, including remote frames that carry no data.

Three flags go to the interrupt logic. One pulse reports that a message was stored. One pulse reports that a message was dropped because the queue was full. A level reports that the queue holds at least one message. A synchronous soft reset discards everything stored.

Top module: `can_rx_queue`

## Requirements
- R1: With the queue not empty, a read returns a field of the head message by offset: 0x50 returns the identifier word, 0x54 the length word, 0x58 data word 1 and 0x5C data word 2. Any other offset returns zero.
- R2: The length word carries the 4-bit length code in bits 31:28, and every other bit of it is zero.
- R3: A read at 0x5C of a non-empty queue removes the head message at the next clock edge. This holds whatever the frame type. Reads at other offsets remove nothing.
- R4: Messages are read out in the order in which they were accepted.
- R5: A message offered while the queue holds DEPTH messages is discarded and the stored messages stay unchanged. The full check uses the occupancy before any read in the same cycle. The overflow pulse is high for the one cycle after the offer.
- R6: An accepted message makes the received pulse high for exactly the one cycle after the accepting edge. The received pulse and the overflow pulse are never high together.
- R7: The not-empty flag is high exactly while the queue holds at least one message.
- R8: A read of an empty queue returns zero at every offset and moves no pointer, including a read at 0x5C.
- R9: Soft reset empties the queue at the next edge, and a message offered in that cycle is not stored.
- R10: The identifier word is stored and returned bit for bit. Its layout is: base identifier in 31:21, substitute remote request in 20, extended flag in 19, extended identifier in 18:1, remote request in 0.
- R11: When a message is offered and the head is retired in the same cycle, with the queue not full, both take effect and the occupancy is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| soft_rst_i | input | 1 | Synchronous queue flush |
| msg_valid_i | input | 1 | Receive engine offers a message this cycle |
| msg_id_i | input | 32 | Identifier word of the offered message |
| msg_dlc_i | input | 4 | Length code of the offered message |
| msg_d1_i | input | 32 | Data word 1 of the offered message |
| msg_d2_i | input | 32 | Data word 2 of the offered message |
| rd_en_i | input | 1 | Software read strobe |
| rd_addr_i | input | ADDR_W | Byte offset of the read |
| rd_data_o | output | 32 | Read data, combinational from the head message |
| rx_ok_o | output | 1 | Pulse: message stored |
| rx_ovf_o | output | 1 | Pulse: message dropped on a full queue |
| rx_not_empty_o | output | 1 | Level: queue holds a message |

## Verification
The bench targets the points where a queue of this kind tends to go wrong. A read at 0x5C of an empty queue is one: a pointer that moved there would return a stale message on a later read. Pushing to a full queue is another: overwriting the oldest entry, or letting a same-cycle read make room, would corrupt the stored order. Reads at the ID, length and data 1 offsets must not retire the head, or later fields would come from the next message. Wrap-around across several fill levels would expose an off-by-one in the pointers. The bench also checks that soft reset leaves nothing readable and that a push coinciding with a pop keeps the occupancy.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
  typedef struct packed {
    logic [31:0] id;
    logic [3:0]  dlc;
    logic [31:0] d1;
    logic [31:0] d2;
  } rxq_msg_t;

  localparam int unsigned OFS_ID  = 'h50;
  localparam int unsigned OFS_LEN = 'h54;
  localparam int unsigned OFS_D1  = 'h58;
  localparam int unsigned OFS_D2  = 'h5C;
  localparam int unsigned DLC_LSB = 28;
endpackage

// File: rtl/rxq_store.sv
module rxq_store
  import rxq_pkg::*;
#(
  parameter int unsigned DEPTH = 4
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     clr_i,
  input  logic     push_i,
  input  rxq_msg_t msg_i,
  input  logic     pop_i,
  output rxq_msg_t head_o,
  output logic     empty_o,
  output logic     acc_o,
  output logic     drop_o
);
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);

  rxq_msg_t         mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic [CNT_W-1:0] cnt;
  logic             full, pop_ok;

  function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full    = (cnt == CNT_W'(DEPTH));
  assign empty_o = (cnt == '0);
  // full is judged before any same-cycle pop
  assign acc_o   = push_i & ~full & ~clr_i;
  assign drop_o  = push_i & full & ~clr_i;
  assign pop_ok  = pop_i & ~empty_o & ~clr_i;
  assign head_o  = mem[rd_ptr];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
    end else if (clr_i) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
    end else begin
      if (acc_o)  wr_ptr <= nxt(wr_ptr);
      if (pop_ok) rd_ptr <= nxt(rd_ptr);
      case ({acc_o, pop_ok})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  always_ff @(posedge clk_i) begin
    if (acc_o) mem[wr_ptr] <= msg_i;
  end

  p_cnt_bound_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt <= CNT_W'(DEPTH));
  p_drop_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drop_o && !pop_ok |=> $stable(cnt) && $stable(wr_ptr));
  p_pop_dec_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_ok && !acc_o |=> cnt == $past(cnt) - 1'b1);
  p_both_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_ok && acc_o |=> $stable(cnt));
  p_clr_empty_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> empty_o);
endmodule

// File: rtl/rxq_rdport.sv
module rxq_rdport
  import rxq_pkg::*;
#(
  parameter int unsigned ADDR_W = 8
) (
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              empty_i,
  input  rxq_msg_t          head_i,
  output logic [31:0]       data_o,
  output logic              pop_o
);
  always_comb begin
    data_o = '0;
    if (!empty_i) begin
      if      (addr_i == ADDR_W'(OFS_ID))  data_o = head_i.id;
      else if (addr_i == ADDR_W'(OFS_LEN)) data_o = {head_i.dlc, {DLC_LSB{1'b0}}};
      else if (addr_i == ADDR_W'(OFS_D1))  data_o = head_i.d1;
      else if (addr_i == ADDR_W'(OFS_D2))  data_o = head_i.d2;
    end
  end

  // last data word retires the head
  assign pop_o = rd_en_i & ~empty_i & (addr_i == ADDR_W'(OFS_D2));
endmodule

// File: rtl/rxq_flags.sv
module rxq_flags (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic acc_i,
  input  logic drop_i,
  input  logic empty_i,
  output logic rx_ok_o,
  output logic ovf_o,
  output logic not_empty_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rx_ok_o <= 1'b0;
      ovf_o   <= 1'b0;
    end else begin
      rx_ok_o <= acc_i;
      ovf_o   <= drop_i;
    end
  end

  assign not_empty_o = ~empty_i;

  p_pulse_excl_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rx_ok_o && ovf_o));
  p_ok_single_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_i |=> rx_ok_o);
endmodule

// File: rtl/can_rx_queue.sv
module can_rx_queue
  import rxq_pkg::*;
#(
  parameter int unsigned DEPTH  = 4,
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              soft_rst_i,
  input  logic              msg_valid_i,
  input  logic [31:0]       msg_id_i,
  input  logic [3:0]        msg_dlc_i,
  input  logic [31:0]       msg_d1_i,
  input  logic [31:0]       msg_d2_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [31:0]       rd_data_o,
  output logic              rx_ok_o,
  output logic              rx_ovf_o,
  output logic              rx_not_empty_o
);
  rxq_msg_t in_msg, head;
  logic     empty, pop, acc, drop;

  assign in_msg = '{id: msg_id_i, dlc: msg_dlc_i, d1: msg_d1_i, d2: msg_d2_i};

  rxq_store #(.DEPTH(DEPTH)) u_store (
    .clk_i, .rst_ni,
    .clr_i  (soft_rst_i),
    .push_i (msg_valid_i),
    .msg_i  (in_msg),
    .pop_i  (pop),
    .head_o (head),
    .empty_o(empty),
    .acc_o  (acc),
    .drop_o (drop)
  );

  rxq_rdport #(.ADDR_W(ADDR_W)) u_rd (
    .rd_en_i,
    .addr_i (rd_addr_i),
    .empty_i(empty),
    .head_i (head),
    .data_o (rd_data_o),
    .pop_o  (pop)
  );

  rxq_flags u_flags (
    .clk_i, .rst_ni,
    .acc_i      (acc),
    .drop_i     (drop),
    .empty_i    (empty),
    .rx_ok_o    (rx_ok_o),
    .ovf_o      (rx_ovf_o),
    .not_empty_o(rx_not_empty_o)
  );

  p_empty_zero_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_i && !rx_not_empty_o |-> rd_data_o == '0);
  p_ok_nonempty_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_ok_o |-> rx_not_empty_o);
  p_ovf_full_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_ovf_o |-> rx_not_empty_o);
endmodule

// File: tb/sim_can_rx_queue.sv
module sim_can_rx_queue;
  localparam int DEPTH = 4;

  logic        clk = 0, rst_n = 0, soft_rst = 0;
  logic        vld = 0, rd_en = 0;
  logic [31:0] id = 0, d1 = 0, d2 = 0;
  logic [3:0]  dlc = 0;
  logic [7:0]  addr = 0;
  logic [31:0] rdata;
  logic        ok, ovf, ne;
  int          checks = 0, fails = 0;
  int          q[$];
  bit          done = 0;

  always #5 clk = ~clk;

  can_rx_queue #(.DEPTH(DEPTH), .ADDR_W(8)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .soft_rst_i(soft_rst),
    .msg_valid_i(vld), .msg_id_i(id), .msg_dlc_i(dlc),
    .msg_d1_i(d1), .msg_d2_i(d2),
    .rd_en_i(rd_en), .rd_addr_i(addr), .rd_data_o(rdata),
    .rx_ok_o(ok), .rx_ovf_o(ovf), .rx_not_empty_o(ne)
  );

  function automatic logic [31:0] e_id(int k);
    return 32'hA5C3_0000 ^ (32'(k) * 32'h0102_0F09);
  endfunction
  function automatic logic [3:0] e_dlc(int k); return 4'(k * 5 + 3); endfunction
  function automatic logic [31:0] e_d1(int k); return ~e_id(k) + 32'(k); endfunction
  function automatic logic [31:0] e_d2(int k); return {e_id(k)[15:0], 16'(k)}; endfunction

  task automatic chk(string r, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", r, act, exp);
    end
  endtask

  task automatic set_msg(int k);
    id = e_id(k); dlc = e_dlc(k); d1 = e_d1(k); d2 = e_d2(k);
  endtask

  // offer message k; returns at the negedge after the accepting edge
  task automatic push(int k);
    @(negedge clk);
    set_msg(k); vld = 1;
    @(negedge clk);
    vld = 0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] v);
    @(negedge clk);
    addr = a; rd_en = 1;
    #1 v = rdata;
    @(negedge clk);
    rd_en = 0;
  endtask

  task automatic check_head(string r);
    logic [31:0] v;
    int k;
    k = q.pop_front();
    rd(8'h50, v); chk({r, " R10 id"}, v, e_id(k));
    rd(8'h54, v); chk({r, " R2 len"}, v, {e_dlc(k), 28'h0});
    rd(8'h58, v); chk({r, " R1 d1"}, v, e_d1(k));
    rd(8'h50, v); chk({r, " R3 no pop on id"}, v, e_id(k));
    rd(8'h5C, v); chk({r, " R1 d2"}, v, e_d2(k));
  endtask

  initial begin
    logic [31:0] v;
    int tag;
    #1;
    chk("R7 reset ne", {31'b0, ne}, 0);
    chk("R6 reset ok", {31'b0, ok}, 0);
    chk("R5 reset ovf", {31'b0, ovf}, 0);
    repeat (2) @(negedge clk);
    rst_n = 1;

    // R8: empty reads, including 0x5C, then check pointer did not move
    rd(8'h5C, v); chk("R8 empty d2", v, 0);
    rd(8'h50, v); chk("R8 empty id", v, 0);
    push(0); q.push_back(0);
    chk("R6 ok pulse", {31'b0, ok}, 1);
    chk("R7 ne after push", {31'b0, ne}, 1);
    @(negedge clk);
    chk("R6 ok single cycle", {31'b0, ok}, 0);
    rd(8'h60, v); chk("R1 other offset", v, 0);
    rd(8'h4C, v); chk("R1 other offset low", v, 0);
    check_head("R8 after empty read");
    chk("R7 ne after drain", {31'b0, ne}, 0);

    // R4: sweep fill levels across wrap-around
    tag = 1;
    for (int round = 0; round < 3; round++) begin
      for (int n = 1; n <= DEPTH; n++) begin
        for (int i = 0; i < n; i++) begin
          push(tag); q.push_back(tag); tag++;
          chk("R6 ok each", {31'b0, ok}, 1);
        end
        for (int i = 0; i < n; i++) begin
          chk("R7 ne level", {31'b0, ne}, 1);
          check_head("R4 order");
        end
        chk("R7 ne empty", {31'b0, ne}, 0);
      end
    end

    // R5: overflow on full queue
    for (int i = 0; i < DEPTH; i++) begin push(tag); q.push_back(tag); tag++; end
    push(999);
    chk("R5 ovf pulse", {31'b0, ovf}, 1);
    chk("R6 no ok on drop", {31'b0, ok}, 0);
    // R5: push + pop on full still drops
    @(negedge clk);
    set_msg(998); vld = 1; addr = 8'h5C; rd_en = 1;
    @(negedge clk);
    vld = 0; rd_en = 0;
    void'(q.pop_front());
    chk("R5 ovf with pop", {31'b0, ovf}, 1);
    for (int i = 0; i < DEPTH - 1; i++) check_head("R5 contents kept");
    chk("R5 drained", {31'b0, ne}, 0);

    // R11: simultaneous push and pop, not full
    push(tag); q.push_back(tag); tag++;
    push(tag); q.push_back(tag); tag++;
    @(negedge clk);
    set_msg(tag); vld = 1; addr = 8'h5C; rd_en = 1;
    @(negedge clk);
    vld = 0; rd_en = 0;
    void'(q.pop_front()); q.push_back(tag); tag++;
    chk("R11 ok", {31'b0, ok}, 1);
    check_head("R11 order");
    check_head("R11 order");
    chk("R11 count", {31'b0, ne}, 0);

    // R9: soft reset, with a same-cycle offer
    push(tag); tag++;
    push(tag); tag++;
    @(negedge clk);
    set_msg(tag); vld = 1; soft_rst = 1;
    @(negedge clk);
    vld = 0; soft_rst = 0;
    chk("R9 ne cleared", {31'b0, ne}, 0);
    chk("R9 no ok", {31'b0, ok}, 0);
    rd(8'h50, v); chk("R9 reads zero", v, 0);
    push(tag); q.push_back(tag); tag++;
    check_head("R9 restart");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog act=timeout exp=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule